// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block holds the 16-bit program counter of a small controller core and decides its next value from one command per accepted cycle. A command is a sequential step, an absolute jump, a subroutine call, a return, a return from interrupt, or a conditional skip. Jump and call destinations are built from two parts: the upper PC bits come from a separately held two-bit page selection, and the lower fourteen bits come from the instruction operand. Calls save their return address on an internal eight-entry hardware stack, and returns take it back. A return from interrupt also turns the global interrupt enable back on. An external interrupt acceptance pulse turns it off.

Commands arrive on a valid/ready handshake. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. The PC register shows the result in the following cycle. Jumps, calls, both kinds of return, and skips whose condition is true all cost a second cycle. During that cycle `busy` is high and `cmd_ready` is low.

Back-pressure rules: while `cmd_ready` is low, a presenting source must hold `cmd_valid` and every command field stable. Nothing it drives has an effect until the edge where `cmd_ready` is high. `cmd_ready` never stays low for more than one cycle. The `skip_cond` input is sampled only with an accepted skip command and is ignored otherwise. `irq_accept` is a plain control input that acts in any cycle.

Top module: `pc_sequencer`

## Requirements
- R1: After reset, `pc` is 0, `gie` is 0, `busy` is 0, `cmd_ready` is 1, the return stack is empty, and both stack error flags are 0.
- R2: An accepted step command (`cmd_op` = 0) sets `pc` to `pc`+1, wrapping modulo 2^16, and leaves `busy` low. Codes 6 and 7 behave as step.
- R3: An accepted jump (`cmd_op` = 1) loads `pc[15:14]` from `page_sel` and `pc[13:0]` from `cmd_target`, and takes two cycles.
- R4: An accepted call (`cmd_op` = 2) pushes the address of the next instruction (`pc`+1) onto the return stack and loads `pc` exactly as a jump does. It takes two cycles.
- R5: An accepted return (`cmd_op` = 3) loads `pc` from the newest stack entry, removes that entry, and takes two cycles.
- R6: An accepted return from interrupt (`cmd_op` = 4) restores `pc` as a return does and sets `gie` to 1.
- R7: An accepted skip (`cmd_op` = 5) with `skip_cond` low advances `pc` by 1 in one cycle. With `skip_cond` high it advances `pc` by 2 and takes two cycles.
- R8: A two-cycle command holds `busy` high and `cmd_ready` low for exactly the one following cycle. A command presented in that cycle is not taken, and `pc` does not change until the command is accepted.
- R9: The return stack is last-in first-out and holds eight return addresses.
- R10: A call while eight entries are held sets the sticky `stk_overflow` flag, drops the new address, and keeps the stored entries. The call still loads `pc`.
- R11: A return of either kind with the stack empty sets the sticky `stk_underflow` flag and loads `pc` with 0.
- R12: `irq_accept` high at a clock edge makes `gie` 0 in the following cycle. It takes priority over a return from interrupt accepted at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code: 0 step, 1 jump, 2 call, 3 return, 4 return from interrupt, 5 skip |
| cmd_target | input | 14 | Low PC bits for a jump or call |
| page_sel | input | 2 | Page bits for the top of a jump or call address |
| skip_cond | input | 1 | Outcome of the skip test, used with a skip command |
| irq_accept | input | 1 | Pulse marking an accepted interrupt |
| pc | output | 16 | Program counter |
| gie | output | 1 | Global interrupt enable |
| busy | output | 1 | Second cycle of a two-cycle command |
| stk_overflow | output | 1 | Sticky: a call found the stack full |
| stk_underflow | output | 1 | Sticky: a return found the stack empty |

## Verification
Jumps are swept over all four page values and a set of operand patterns that includes all-zeros, all-ones and alternating bits. A page bit and a target bit swapped or shifted into the wrong position therefore give a different PC. Calls are nested with distinct targets until the stack is one past full, then unwound one return past empty. This separates correct LIFO order and the drop-on-full rule from an off-by-one pointer, and shows both sticky flags. Skips are issued with both condition values, and the number of stall cycles after every command is measured. This tells a one-cycle step apart from a two-cycle one, and a skip that advances by 2 apart from a plain step. Interrupt enable is driven by a return from interrupt alone, by an accept pulse alone, and by both at the same edge, which exposes the wrong priority.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4,
    OP_SKIP = 3'd5
  } pc_op_e;

  localparam int unsigned DEF_PC_W   = 16;
  localparam int unsigned DEF_PAGE_W = 2;
  localparam int unsigned DEF_DEPTH  = 8;

endpackage

// File: rtl/pcseq_ret_stack.sv
module pcseq_ret_stack #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data,
  output logic         empty,
  output logic         full,
  output logic         overflow,
  output logic         underflow
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] count_q;
  logic [W-1:0]     entry_q [DEPTH];
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             do_push;
  logic             do_pop;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign wr_idx  = IDX_W'(count_q);
  assign rd_idx  = IDX_W'(count_q - 1'b1);
  assign top_data = empty ? '0 : entry_q[rd_idx];

  // one register per entry, written only at the free slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[g] <= '0;
      end else if (do_push && (wr_idx == IDX_W'(g))) begin
        entry_q[g] <= push_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (do_push) begin
      count_q <= count_q + 1'b1;
    end else if (do_pop) begin
      count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (push && full) overflow <= 1'b1;
      if (pop && empty) underflow <= 1'b1;
    end
  end

  assert_push_lands_on_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (top_data == $past(push_data)));

  assert_full_push_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (full && overflow && top_data == $past(top_data)));

  assert_empty_pop_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> (empty && underflow));

  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

// File: rtl/pcseq_gie.sv
module pcseq_gie (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr_en,
  output logic gie
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie <= 1'b0;
    end else if (clr_en) begin
      gie <= 1'b0;
    end else if (set_en) begin
      gie <= 1'b1;
    end
  end

  assert_accept_clears_gie_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !gie);

  assert_reti_sets_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> gie);

endmodule

// File: rtl/pcseq_next_pc.sv
module pcseq_next_pc
  import pcseq_pkg::*;
#(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned PAGE_W = 2
) (
  input  logic [2:0]           op,
  input  logic [PC_W-1:0]      pc_cur,
  input  logic [PAGE_W-1:0]    page,
  input  logic [PC_W-PAGE_W-1:0] target,
  input  logic                 skip_cond,
  input  logic [PC_W-1:0]      stk_top,
  input  logic                 stk_empty,
  output logic [PC_W-1:0]      pc_nxt,
  output logic                 two_cycle,
  output logic                 push_req,
  output logic                 pop_req,
  output logic                 reti_req
);
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_far;
  logic [PC_W-1:0] pc_ret;

  assign pc_inc = pc_cur + PC_W'(1);
  assign pc_far = {page, target};
  assign pc_ret = stk_empty ? '0 : stk_top;

  always_comb begin
    pc_nxt    = pc_inc;
    two_cycle = 1'b0;
    push_req  = 1'b0;
    pop_req   = 1'b0;
    reti_req  = 1'b0;
    case (pc_op_e'(op))
      OP_JUMP: begin
        pc_nxt    = pc_far;
        two_cycle = 1'b1;
      end
      OP_CALL: begin
        pc_nxt    = pc_far;
        two_cycle = 1'b1;
        push_req  = 1'b1;
      end
      OP_RET: begin
        pc_nxt    = pc_ret;
        two_cycle = 1'b1;
        pop_req   = 1'b1;
      end
      OP_RETI: begin
        pc_nxt    = pc_ret;
        two_cycle = 1'b1;
        pop_req   = 1'b1;
        reti_req  = 1'b1;
      end
      OP_SKIP: begin
        if (skip_cond) begin
          pc_nxt    = pc_cur + PC_W'(2);
          two_cycle = 1'b1;
        end
      end
      default: begin
        pc_nxt = pc_inc;
      end
    endcase
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int unsigned PC_W        = DEF_PC_W,
  parameter int unsigned PAGE_W      = DEF_PAGE_W,
  parameter int unsigned STACK_DEPTH = DEF_DEPTH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [2:0]               cmd_op,
  input  logic [PC_W-PAGE_W-1:0]   cmd_target,
  input  logic [PAGE_W-1:0]        page_sel,
  input  logic                     skip_cond,
  input  logic                     irq_accept,
  output logic [PC_W-1:0]          pc,
  output logic                     gie,
  output logic                     busy,
  output logic                     stk_overflow,
  output logic                     stk_underflow
);
  logic            accept;
  logic            busy_q;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_nxt;
  logic [PC_W-1:0] stk_top;
  logic            stk_empty;
  logic            stk_full;
  logic            two_cycle;
  logic            push_req;
  logic            pop_req;
  logic            reti_req;

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready;
  assign pc        = pc_q;
  assign busy      = busy_q;

  pcseq_next_pc #(
    .PC_W   (PC_W),
    .PAGE_W (PAGE_W)
  ) u_next (
    .op        (cmd_op),
    .pc_cur    (pc_q),
    .page      (page_sel),
    .target    (cmd_target),
    .skip_cond (skip_cond),
    .stk_top   (stk_top),
    .stk_empty (stk_empty),
    .pc_nxt    (pc_nxt),
    .two_cycle (two_cycle),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .reti_req  (reti_req)
  );

  pcseq_ret_stack #(
    .W     (PC_W),
    .DEPTH (STACK_DEPTH)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept && push_req),
    .pop       (accept && pop_req),
    .push_data (pc_q + PC_W'(1)),
    .top_data  (stk_top),
    .empty     (stk_empty),
    .full      (stk_full),
    .overflow  (stk_overflow),
    .underflow (stk_underflow)
  );

  pcseq_gie u_gie (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (accept && reti_req),
    .clr_en (irq_accept),
    .gie    (gie)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= accept && two_cycle;
      if (accept) pc_q <= pc_nxt;
    end
  end

  assert_step_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 3'd0) |=> (pc == PC_W'($past(pc) + 1) && !busy));

  assert_jump_paged_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 3'd1) |=> (pc == {$past(page_sel), $past(cmd_target)} && busy));

  assert_call_saves_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 3'd2 && !stk_full) |=> (stk_top == PC_W'($past(pc) + 1) && busy));

  assert_return_from_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 3'd3 && !stk_empty) |=> (pc == $past(stk_top) && busy));

  assert_skip_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 3'd5 && skip_cond) |=> (pc == PC_W'($past(pc) + 2) && busy));

  assert_skip_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 3'd5 && !skip_cond) |=> (pc == PC_W'($past(pc) + 1) && !busy));

  assert_single_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && pc == $past(pc)));

  assert_empty_return_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (cmd_op == 3'd3 || cmd_op == 3'd4) && stk_empty) |=> (pc == '0));

endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [13:0] cmd_target = '0;
  logic [1:0]  page_sel = '0;
  logic        skip_cond = 1'b0;
  logic        irq_accept = 1'b0;
  logic [15:0] pc;
  logic        gie, busy, stk_overflow, stk_underflow;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [15:0] m_pc = '0;
  logic [15:0] m_stk [8];
  int          m_cnt = 0;
  logic        m_gie = 1'b0, m_ovf = 1'b0, m_unf = 1'b0;
  int          m_stall = 0;

  always #10 clk = ~clk;

  pc_sequencer u_pc_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_target(cmd_target), .page_sel(page_sel),
    .skip_cond(skip_cond), .irq_accept(irq_accept), .pc(pc), .gie(gie),
    .busy(busy), .stk_overflow(stk_overflow), .stk_underflow(stk_underflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " pc"}, 32'(pc), 32'(m_pc));
    chk({req, " busy"}, 32'(busy), 32'(m_stall));
    chk({req, " gie"}, 32'(gie), 32'(m_gie));
    chk({req, " ovf"}, 32'(stk_overflow), 32'(m_ovf));
    chk({req, " unf"}, 32'(stk_underflow), 32'(m_unf));
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic issue(input string req, input logic [2:0] op, input logic [13:0] tgt,
                       input logic [1:0] pg, input logic sc, input logic irq);
    int waits = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_target = tgt; page_sel = pg; skip_cond = sc;
    irq_accept = irq;
    while (!cmd_ready) begin
      @(negedge clk);
      waits++;
    end
    chk("R8 stall cycles", 32'(waits), 32'(m_stall));
    @(negedge clk);
    cmd_valid = 1'b0; irq_accept = 1'b0;
    m_stall = 0;
    case (op)
      3'd1: begin m_pc = {pg, tgt}; m_stall = 1; end
      3'd2: begin
        if (m_cnt < 8) begin m_stk[m_cnt] = m_pc + 16'd1; m_cnt++; end
        else m_ovf = 1'b1;
        m_pc = {pg, tgt}; m_stall = 1;
      end
      3'd3, 3'd4: begin
        if (m_cnt > 0) begin m_cnt--; m_pc = m_stk[m_cnt]; end
        else begin m_unf = 1'b1; m_pc = '0; end
        if (op == 3'd4) m_gie = 1'b1;
        m_stall = 1;
      end
      3'd5: begin
        m_pc = m_pc + (sc ? 16'd2 : 16'd1);
        m_stall = sc ? 1 : 0;
      end
      default: m_pc = m_pc + 16'd1;
    endcase
    if (irq) m_gie = 1'b0;
    chk_state(req);
  endtask

  task automatic pulse_irq();
    irq_accept = 1'b1;
    @(negedge clk);
    irq_accept = 1'b0;
    m_gie = 1'b0;
    m_stall = 0;
    chk("R12 irq clears gie", 32'(gie), 32'(0));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [13:0] pats [6];
    pats[0] = 14'h0000; pats[1] = 14'h3FFF; pats[2] = 14'h1555;
    pats[3] = 14'h2AAA; pats[4] = 14'h0001; pats[5] = 14'h2000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_state("R1 reset");
    chk("R1 ready", 32'(cmd_ready), 32'(1));

    // R2 sequential steps
    for (int i = 0; i < 10; i++) issue("R2 step", 3'd0, 14'h0, 2'd0, 1'b0, 1'b0);
    issue("R2 op6", 3'd6, 14'h3, 2'd1, 1'b0, 1'b0);
    issue("R2 op7", 3'd7, 14'h3, 2'd1, 1'b1, 1'b0);

    // R3 paged jump sweep
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 6; t++) begin
        issue("R3 jump", 3'd1, pats[t], 2'(p), 1'b0, 1'b0);
        issue("R2 after jump", 3'd0, 14'h0, 2'd0, 1'b0, 1'b0);
      end
    // R2 wrap
    issue("R3 jump top", 3'd1, 14'h3FFF, 2'd3, 1'b0, 1'b0);
    issue("R2 wrap", 3'd0, 14'h0, 2'd0, 1'b0, 1'b0);

    // R7 skip both outcomes
    for (int i = 0; i < 8; i++) issue("R7 skip", 3'd5, 14'h0, 2'd0, 1'(i % 3 == 0), 1'b0);

    // R8 held command during stall
    issue("R8 jump", 3'd1, 14'h0123, 2'd2, 1'b0, 1'b0);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_target = 14'h3333; page_sel = 2'd1;
    chk("R8 ready low", 32'(cmd_ready), 32'(0));
    @(negedge clk);
    chk("R8 pc held", 32'(pc), 32'(m_pc));
    chk("R8 ready back", 32'(cmd_ready), 32'(1));
    @(negedge clk);
    cmd_valid = 1'b0;
    m_pc = {2'd1, 14'h3333};
    chk("R8 taken late", 32'(pc), 32'(m_pc));
    chk("R8 busy", 32'(busy), 32'(1));
    m_stall = 1;

    // R4 R9 R10 nested calls past full
    for (int i = 0; i < 9; i++) begin
      issue("R4 call", 3'd2, 14'(14'h0100 * (i + 1) + i), 2'(i), 1'b0, 1'b0);
      issue("R2 in sub", 3'd0, 14'h0, 2'd0, 1'b0, 1'b0);
    end
    chk("R10 overflow", 32'(stk_overflow), 32'(1));
    // R5 R9 unwind past empty (R11)
    for (int i = 0; i < 9; i++) issue("R5 ret", 3'd3, 14'h0, 2'd0, 1'b0, 1'b0);
    chk("R11 underflow", 32'(stk_underflow), 32'(1));
    chk("R11 pc zero", 32'(pc), 32'(0));

    // R6 R12 interrupt enable
    issue("R4 call", 3'd2, 14'h0ABC, 2'd1, 1'b0, 1'b0);
    issue("R6 reti", 3'd4, 14'h0, 2'd0, 1'b0, 1'b0);
    chk("R6 gie set", 32'(gie), 32'(1));
    pulse_irq();
    issue("R4 call", 3'd2, 14'h1234, 2'd2, 1'b0, 1'b0);
    issue("R12 reti with irq", 3'd4, 14'h0, 2'd0, 1'b0, 1'b1);
    chk("R12 irq wins", 32'(gie), 32'(0));
    issue("R6 reti empty", 3'd4, 14'h0, 2'd0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule